// File: doc/BRIEF.md
# Soft-start and fault sequencer

This block governs the start-up and fault behaviour of a digital full-bridge PWM controller. It holds a soft-start level that bounds the PWM command, raises that level slowly after power-up or after any fault clears, and lowers it fast when an overcurrent is seen. After that fast soft stop it restarts on its own with a complete soft start from zero.

All thresholds act on digitized values: supply, reference, current-sense and command codes. A single external-off flag and a per-cycle step rate are also inputs. Two kinds of shutdown are kept apart. A supply lockout or a reference failure clears the level at once. An overcurrent gives a controlled ramp-down at ten times the normal step. A separate peak comparison only ends the present on-time, for that cycle alone.

Every input is registered once before any comparison uses it. The supply has a second register for its hysteresis flag. The outputs are the level, the limited PWM command, an output-enable flag, a cycle-terminate flag and a state code.

Top module: `softstart_fault_seq`

## Requirements
- R1: While reset is held, state is 0, the level is 0, and out_en, cyc_term and pwm_lim are all 0.
- R2: Supply lockout has hysteresis. Operation is allowed only once the supply code has exceeded UV_ON (704). After that it is withdrawn only when the code falls below UV_OFF (576). A code between the two keeps the previous condition.
- R3: A hard fault clears the level to 0 and moves the state to OFF on the next edge, ahead of every other condition. A hard fault is a supply lockout or a reference code below REF_MIN (512).
- R4: In SOFT_START the level rises by step_rate on each cycle and saturates at full scale (1023) without wrapping. On the edge where it is already at full scale the state moves to RUN, and RUN holds the level.
- R5: An overcurrent moves SOFT_START or RUN to SOFT_STOP. An overcurrent is a current-sense code at or above CS_OC (1000). In SOFT_STOP the level falls by 10 × step_rate per cycle and floors at 0.
- R6: In SOFT_STOP, once the level is below SS_LOW (102), the state returns to SOFT_START with the level cleared to 0, and the ramp-up starts again.
- R7: With no hard fault present, ext_off moves the state to DISABLED and clears the level. Overcurrent takes priority in SOFT_START and RUN. When ext_off is released, the state moves to SOFT_START from level 0.
- R8: out_en is 1 only in SOFT_START or RUN with the level at or above SS_LOW.
- R9: A current-sense code above CS_PEAK (800) and below CS_OC sets cyc_term while out_en is 1. It does not change the state or the level.
- R10: pwm_lim equals the smaller of the registered pwm_cmd and the level.
- R11: The state encoding is OFF=0, SOFT_START=1, RUN=2, SOFT_STOP=3, DISABLED=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_code | input | DW | Digitized supply voltage |
| ref_code | input | DW | Digitized reference voltage |
| cs_code | input | DW | Digitized current-sense value |
| ext_off | input | 1 | External shutdown request |
| step_rate | input | RW | Soft-start increment per cycle |
| pwm_cmd | input | DW | Unlimited PWM command |
| ss_level | output | DW | Soft-start level |
| pwm_lim | output | DW | Command limited by the level |
| out_en | output | 1 | Output stages may switch |
| cyc_term | output | 1 | End the present on-time |
| state | output | 3 | Sequencer state code |

## Verification
Directed sequences walk the block through its main cases:
- The supply is parked inside the hysteresis band, both before start and while running, which separates the start threshold from the stop threshold.
- A long ramp with a small step shows saturation at full scale and the hand-over to RUN.
- A peak-zone current and then an overcurrent current separate cycle termination from soft stop, and the ten-fold ramp-down is measured step by step.
- Reference failure and external shutdown are each applied from RUN, which separates an immediate clear from the automatic restart.

A long constrained-random run then mixes sticky supply, reference and off conditions with per-cycle current draws across all three current zones. This exposes ordering between competing events.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

   typedef enum logic [2:0] {
      ST_OFF   = 3'd0,
      ST_START = 3'd1,
      ST_RUN   = 3'd2,
      ST_STOP  = 3'd3,
      ST_DIS   = 3'd4
   } sfs_state_e;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_UP    = 2'd1,
      OP_DOWN  = 2'd2,
      OP_CLEAR = 2'd3
   } sfs_op_e;

   typedef struct packed {
      logic hard;
      logic oc;
      logic peak;
      logic ext;
   } sfs_flags_t;

endpackage

// File: rtl/sfs_sample.sv
module sfs_sample #(
   parameter int DW     = 10,
   parameter int RW     = 6,
   parameter int UV_ON  = 704,
   parameter int UV_OFF = 576
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] sup_i,
   input  logic [DW-1:0] ref_i,
   input  logic [DW-1:0] cs_i,
   input  logic [DW-1:0] cmd_i,
   input  logic          ext_i,
   input  logic [RW-1:0] rate_i,
   output logic [DW-1:0] ref_q,
   output logic [DW-1:0] cs_q,
   output logic [DW-1:0] cmd_q,
   output logic          ext_q,
   output logic [RW-1:0] rate_q,
   output logic          pwr_ok_q
);
   localparam logic [DW-1:0] ON_C  = DW'(UV_ON);
   localparam logic [DW-1:0] OFF_C = DW'(UV_OFF);

   logic [DW-1:0] sup_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sup_q    <= '0;
         ref_q    <= '0;
         cs_q     <= '0;
         cmd_q    <= '0;
         ext_q    <= 1'b0;
         rate_q   <= '0;
         pwr_ok_q <= 1'b0;
      end else begin
         sup_q  <= sup_i;
         ref_q  <= ref_i;
         cs_q   <= cs_i;
         cmd_q  <= cmd_i;
         ext_q  <= ext_i;
         rate_q <= rate_i;
         if (pwr_ok_q)
            pwr_ok_q <= !(sup_q < OFF_C);
         else
            pwr_ok_q <= (sup_q > ON_C);
      end
   end
endmodule

// File: rtl/sfs_classify.sv
module sfs_classify
   import sfs_pkg::*;
#(
   parameter int DW      = 10,
   parameter int REF_MIN = 512,
   parameter int CS_PEAK = 800,
   parameter int CS_OC   = 1000
) (
   input  logic          pwr_ok,
   input  logic [DW-1:0] ref_q,
   input  logic [DW-1:0] cs_q,
   input  logic          ext_q,
   output sfs_flags_t    flags
);
   localparam logic [DW-1:0] REF_C  = DW'(REF_MIN);
   localparam logic [DW-1:0] PEAK_C = DW'(CS_PEAK);
   localparam logic [DW-1:0] OC_C   = DW'(CS_OC);

   always_comb begin
      flags.hard = !pwr_ok || (ref_q < REF_C);
      flags.oc   = (cs_q >= OC_C);
      flags.peak = (cs_q > PEAK_C);
      flags.ext  = ext_q;
   end
endmodule

// File: rtl/sfs_ramp.sv
module sfs_ramp
   import sfs_pkg::*;
#(
   parameter int DW        = 10,
   parameter int RW        = 6,
   parameter int FAST_MULT = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sfs_op_e       op,
   input  logic [RW-1:0] rate,
   output logic [DW-1:0] level
);
   localparam int SW = RW + $clog2(FAST_MULT + 1);
   localparam int AW = ((DW > SW) ? DW : SW) + 1;
   localparam logic [AW-1:0] FULL_A = AW'((1 << DW) - 1);

   logic [AW-1:0] lvl_a, up_sum, fast_step;
   logic [DW-1:0] nxt;

   always_comb begin
      lvl_a     = AW'(level);
      up_sum    = lvl_a + AW'(rate);
      fast_step = AW'(rate) * AW'(FAST_MULT);
      unique case (op)
         OP_UP:    nxt = (up_sum > FULL_A) ? FULL_A[DW-1:0] : up_sum[DW-1:0];
         OP_DOWN:  nxt = (fast_step > lvl_a) ? '0 : DW'(lvl_a - fast_step);
         OP_CLEAR: nxt = '0;
         default:  nxt = level;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level <= '0;
      else        level <= nxt;
   end
endmodule

// File: rtl/sfs_ctrl.sv
module sfs_ctrl
   import sfs_pkg::*;
#(
   parameter int DW     = 10,
   parameter int SS_LOW = 102
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sfs_flags_t    flags,
   input  logic [DW-1:0] level,
   output sfs_state_e    st,
   output sfs_op_e       op
);
   localparam logic [DW-1:0] FULL_C = '1;
   localparam logic [DW-1:0] LOW_C  = DW'(SS_LOW);

   sfs_state_e nxt;

   always_comb begin
      nxt = st;
      op  = OP_HOLD;
      if (flags.hard) begin
         nxt = ST_OFF;
         op  = OP_CLEAR;
      end else begin
         unique case (st)
            ST_OFF: begin
               op  = OP_CLEAR;
               nxt = flags.ext ? ST_DIS : ST_START;
            end
            ST_START: begin
               if (flags.oc) begin
                  nxt = ST_STOP;
                  op  = OP_DOWN;
               end else if (flags.ext) begin
                  nxt = ST_DIS;
                  op  = OP_CLEAR;
               end else begin
                  op = OP_UP;
                  if (level == FULL_C) nxt = ST_RUN;
               end
            end
            ST_RUN: begin
               if (flags.oc) begin
                  nxt = ST_STOP;
                  op  = OP_DOWN;
               end else if (flags.ext) begin
                  nxt = ST_DIS;
                  op  = OP_CLEAR;
               end
            end
            ST_STOP: begin
               if (flags.ext) begin
                  nxt = ST_DIS;
                  op  = OP_CLEAR;
               end else if (level < LOW_C) begin
                  nxt = ST_START;
                  op  = OP_CLEAR;
               end else begin
                  op = OP_DOWN;
               end
            end
            ST_DIS: begin
               op = OP_CLEAR;
               if (!flags.ext) nxt = ST_START;
            end
            default: begin
               nxt = ST_OFF;
               op  = OP_CLEAR;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_OFF;
      else        st <= nxt;
   end
endmodule

// File: rtl/softstart_fault_seq.sv
module softstart_fault_seq
   import sfs_pkg::*;
#(
   parameter int DW        = 10,
   parameter int RW        = 6,
   parameter int UV_ON     = 704,
   parameter int UV_OFF    = 576,
   parameter int REF_MIN   = 512,
   parameter int CS_PEAK   = 800,
   parameter int CS_OC     = 1000,
   parameter int SS_LOW    = 102,
   parameter int FAST_MULT = 10,
   parameter bit GATE_PEAK = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] supply_code,
   input  logic [DW-1:0] ref_code,
   input  logic [DW-1:0] cs_code,
   input  logic          ext_off,
   input  logic [RW-1:0] step_rate,
   input  logic [DW-1:0] pwm_cmd,
   output logic [DW-1:0] ss_level,
   output logic [DW-1:0] pwm_lim,
   output logic          out_en,
   output logic          cyc_term,
   output logic [2:0]    state
);
   localparam int FULL = (1 << DW) - 1;
   localparam logic [DW-1:0] LOW_C = DW'(SS_LOW);

   generate
      if (DW < 4 || DW > 24) begin : g_bad_dw
         $error("DW out of range");
      end
      if (UV_OFF >= UV_ON || UV_ON > FULL) begin : g_bad_uv
         $error("supply thresholds invalid");
      end
      if (CS_PEAK >= CS_OC || CS_OC > FULL) begin : g_bad_cs
         $error("current thresholds invalid");
      end
      if (SS_LOW < 1 || SS_LOW > FULL || REF_MIN > FULL) begin : g_bad_lvl
         $error("level thresholds invalid");
      end
      if (FAST_MULT < 1) begin : g_bad_mult
         $error("fast multiplier must be positive");
      end
   endgenerate

   logic [DW-1:0] ref_q, cs_q, cmd_q;
   logic          ext_q, pwr_ok_q;
   logic [RW-1:0] rate_q;
   sfs_flags_t    flags;
   sfs_state_e    st;
   sfs_op_e       op;

   sfs_sample #(.DW(DW), .RW(RW), .UV_ON(UV_ON), .UV_OFF(UV_OFF)) u_sample (
      .clk      (clk),
      .rst_n    (rst_n),
      .sup_i    (supply_code),
      .ref_i    (ref_code),
      .cs_i     (cs_code),
      .cmd_i    (pwm_cmd),
      .ext_i    (ext_off),
      .rate_i   (step_rate),
      .ref_q    (ref_q),
      .cs_q     (cs_q),
      .cmd_q    (cmd_q),
      .ext_q    (ext_q),
      .rate_q   (rate_q),
      .pwr_ok_q (pwr_ok_q)
   );

   sfs_classify #(.DW(DW), .REF_MIN(REF_MIN), .CS_PEAK(CS_PEAK), .CS_OC(CS_OC)) u_class (
      .pwr_ok (pwr_ok_q),
      .ref_q  (ref_q),
      .cs_q   (cs_q),
      .ext_q  (ext_q),
      .flags  (flags)
   );

   sfs_ctrl #(.DW(DW), .SS_LOW(SS_LOW)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .level (ss_level),
      .st    (st),
      .op    (op)
   );

   sfs_ramp #(.DW(DW), .RW(RW), .FAST_MULT(FAST_MULT)) u_ramp (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .rate  (rate_q),
      .level (ss_level)
   );

   always_comb begin
      state   = st;
      out_en  = ((st == ST_START) || (st == ST_RUN)) && (ss_level >= LOW_C);
      pwm_lim = (cmd_q < ss_level) ? cmd_q : ss_level;
   end

   generate
      if (GATE_PEAK) begin : g_peak_gated
         assign cyc_term = flags.peak && out_en;
      end else begin : g_peak_raw
         assign cyc_term = flags.peak;
      end
   endgenerate
endmodule

// File: rtl/softstart_fault_seq_chk.sv
module softstart_fault_seq_chk #(
   parameter int DW     = 10,
   parameter int SS_LOW = 102
) (
   input logic          clk,
   input logic          rst_n,
   input logic [2:0]    state,
   input logic [DW-1:0] ss_level,
   input logic [DW-1:0] pwm_lim,
   input logic          out_en
);
   localparam logic [DW-1:0] LOW_C = DW'(SS_LOW);

   // R3
   off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd0) |-> (ss_level == '0));

   // R7
   dis_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'd4) |-> (ss_level == '0));

   // R8
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |-> (((state == 3'd1) || (state == 3'd2)) && (ss_level >= LOW_C)));

   // R6
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == 3'd1) && ($past(state) == 3'd3)) |-> (ss_level == '0));

   // R4
   rise_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == 3'd1) && ($past(state) == 3'd1)) |-> (ss_level >= $past(ss_level)));

   // R4
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == 3'd2) && ($past(state) == 3'd2)) |-> $stable(ss_level));

   // R5
   stop_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == 3'd3) && ($past(state) == 3'd3)) |-> (ss_level <= $past(ss_level)));

   // R10
   lim_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_lim <= ss_level);

   // R11
   enc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      state <= 3'd4);
endmodule

bind softstart_fault_seq softstart_fault_seq_chk #(.DW(DW), .SS_LOW(SS_LOW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state    (state),
   .ss_level (ss_level),
   .pwm_lim  (pwm_lim),
   .out_en   (out_en)
);

// File: tb/sim_softstart_fault_seq.sv
module sim_softstart_fault_seq;
   localparam int M_ON = 704, M_OFF = 576, M_REF = 512;
   localparam int M_PEAK = 800, M_OC = 1000, M_LOW = 102, M_FULL = 1023;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [9:0] supply_code = '0, ref_code = '0, cs_code = '0, pwm_cmd = '0;
   logic       ext_off = 1'b0;
   logic [5:0] step_rate = '0;
   logic [9:0] ss_level, pwm_lim;
   logic       out_en, cyc_term;
   logic [2:0] state;

   int checks = 0, errors = 0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   softstart_fault_seq u0 (
      .clk(clk), .rst_n(rst_n), .supply_code(supply_code), .ref_code(ref_code),
      .cs_code(cs_code), .ext_off(ext_off), .step_rate(step_rate), .pwm_cmd(pwm_cmd),
      .ss_level(ss_level), .pwm_lim(pwm_lim), .out_en(out_en), .cyc_term(cyc_term),
      .state(state)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model, built from the requirements
   int m_sup, m_ref, m_cs, m_cmd, m_rate, m_lvl, m_st;
   bit m_dis, m_pok;

   function automatic int f_up(int lvl, int r);
      return (lvl + r > M_FULL) ? M_FULL : lvl + r;
   endfunction

   function automatic int f_down(int lvl, int r);
      return (10 * r > lvl) ? 0 : lvl - 10 * r;
   endfunction

   function automatic bit f_en(int st, int lvl);
      return ((st == 1) || (st == 2)) && (lvl >= M_LOW);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_sup <= 0; m_ref <= 0; m_cs <= 0; m_cmd <= 0; m_rate <= 0;
         m_dis <= 0; m_pok <= 0; m_st <= 0; m_lvl <= 0;
      end else begin
         int nst, nlvl;
         bit hard, oc;
         hard = !m_pok || (m_ref < M_REF);
         oc   = (m_cs >= M_OC);
         nst  = m_st;
         nlvl = m_lvl;
         if (hard) begin nst = 0; nlvl = 0; end
         else case (m_st)
            0: begin nlvl = 0; nst = m_dis ? 4 : 1; end
            1: if (oc) begin nst = 3; nlvl = f_down(m_lvl, m_rate); end
               else if (m_dis) begin nst = 4; nlvl = 0; end
               else begin nlvl = f_up(m_lvl, m_rate); if (m_lvl == M_FULL) nst = 2; end
            2: if (oc) begin nst = 3; nlvl = f_down(m_lvl, m_rate); end
               else if (m_dis) begin nst = 4; nlvl = 0; end
            3: if (m_dis) begin nst = 4; nlvl = 0; end
               else if (m_lvl < M_LOW) begin nst = 1; nlvl = 0; end
               else nlvl = f_down(m_lvl, m_rate);
            default: begin nlvl = 0; if (!m_dis) nst = 1; end
         endcase
         m_st  <= nst;
         m_lvl <= nlvl;
         m_pok <= m_pok ? !(m_sup < M_OFF) : (m_sup > M_ON);
         m_sup <= supply_code; m_ref <= ref_code; m_cs <= cs_code;
         m_cmd <= pwm_cmd; m_rate <= step_rate; m_dis <= ext_off;
      end
   end

   always @(negedge clk) begin
      if (cmp_on) begin
         bit e_en;
         e_en = f_en(m_st, m_lvl);
         chk(ss_level == m_lvl, "R5 model level", ss_level, m_lvl);
         chk(state == m_st, "R11 model state", state, m_st);
         chk(out_en == e_en, "R8 model out_en", out_en, e_en);
         chk(cyc_term == ((m_cs > M_PEAK) && e_en), "R9 model cyc_term", cyc_term,
             (m_cs > M_PEAK) && e_en);
         chk(pwm_lim == ((m_cmd < m_lvl) ? m_cmd : m_lvl), "R10 model pwm_lim", pwm_lim,
             (m_cmd < m_lvl) ? m_cmd : m_lvl);
      end
   end

   bit got;
   task automatic wait_state(input int s, input int maxc);
      got = 1'b0;
      for (int i = 0; i < maxc; i++) begin
         @(negedge clk);
         if (state == s) begin got = 1'b1; break; end
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int lv0;
      void'($urandom(32'd20240611));
      supply_code = 10'd650; ref_code = 10'd640; step_rate = 6'd8;
      repeat (3) @(negedge clk);
      // R1 R11: reset values
      chk(state == 0, "R1 reset state", state, 0);
      chk(ss_level == 0 && pwm_lim == 0, "R1 reset level", ss_level, 0);
      chk(!out_en && !cyc_term, "R1 reset flags", out_en, 0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      repeat (12) @(negedge clk);
      chk(state == 0, "R2 no start inside band", state, 0);
      supply_code = 10'd800;
      wait_state(1, 10);
      chk(got && ss_level == 0, "R2 start above UV_ON", state, 1);
      wait_state(2, 300);
      chk(got && ss_level == M_FULL, "R4 saturate then RUN", ss_level, M_FULL);
      chk(out_en == 1'b1, "R8 enabled in RUN", out_en, 1);
      pwm_cmd = 10'd300;
      cs_code = 10'd900;
      repeat (3) @(negedge clk);
      chk(cyc_term == 1'b1, "R9 peak terminates cycle", cyc_term, 1);
      chk(state == 2 && ss_level == M_FULL, "R9 peak keeps RUN", state, 2);
      chk(pwm_lim == 300, "R10 command below level", pwm_lim, 300);
      cs_code = 10'd1010;
      wait_state(3, 6);
      chk(got, "R5 overcurrent enters SOFT_STOP", state, 3);
      lv0 = ss_level;
      cs_code = 10'd0;
      @(negedge clk);
      chk(lv0 - ss_level == 80, "R5 fast step is 10x rate", lv0 - ss_level, 80);
      wait_state(1, 30);
      chk(got && ss_level == 0, "R6 restart from zero", ss_level, 0);
      wait_state(2, 300);
      supply_code = 10'd650;
      repeat (10) @(negedge clk);
      chk(state == 2, "R2 stays on inside band", state, 2);
      supply_code = 10'd500;
      wait_state(0, 8);
      chk(got && ss_level == 0, "R3 lockout clears level", ss_level, 0);
      supply_code = 10'd800;
      wait_state(2, 320);
      ref_code = 10'd400;
      wait_state(0, 6);
      chk(got && ss_level == 0, "R3 reference failure", state, 0);
      ref_code = 10'd640;
      wait_state(2, 320);
      ext_off = 1'b1;
      wait_state(4, 6);
      chk(got && ss_level == 0 && !out_en, "R7 external off", state, 4);
      ext_off = 1'b0;
      wait_state(1, 6);
      chk(got && ss_level == 0, "R7 release restarts from zero", ss_level, 0);

      // constrained random phase, checked against the model every cycle
      for (int c = 0; c < 8000; c++) begin
         if (c % 32 == 0) begin
            int p;
            p = $urandom_range(99);
            supply_code = (p < 80) ? 10'd800 : (p < 90) ? 10'($urandom_range(580, 700))
                                             : 10'($urandom_range(0, 1023));
            ref_code  = ($urandom_range(99) < 5) ? 10'($urandom_range(0, 511)) : 10'd640;
            ext_off   = ($urandom_range(99) < 6);
            step_rate = 6'($urandom_range(1, 63));
         end
         begin
            int q;
            q = $urandom_range(99);
            cs_code = (q < 85) ? 10'($urandom_range(0, 700)) :
                      (q < 97) ? 10'($urandom_range(801, 999)) : 10'($urandom_range(1000, 1023));
         end
         pwm_cmd = 10'($urandom_range(0, 1023));
         @(negedge clk);
      end
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule